// File: doc/BRIEF.md
# Serial EEPROM Byte Command Engine

This block is a two-wire bus master that moves a serial EEPROM transaction forward one primitive at a time. Host logic writes a 4-bit command code, plus a data byte when the command sends one, and the engine then produces a START, a STOP, an outgoing byte with its acknowledge slot, or an incoming byte that it either acknowledges or leaves unacknowledged. The data line is open-drain: the block only ever pulls it low or releases it.

Bus timing comes from a quarter-period divider. Every bit occupies one slot of four quarters: two with the clock low, where the data line may change, and two with the clock high, where the data line is sampled. Once the first bus command has run, the clock keeps toggling in idle slots between commands and only stops, parked high, when the halt command (code 0000) is executed. Results appear on the status outputs: busy, an error flag, the received byte and the acknowledge bit returned by the slave after a transmit.

Top module: `ee_byte_master`

## Requirements
- R1: Code 1001 produces a START slot: clock low for two quarters with data released, clock high for two quarters, and the data line pulled low at the start of the fourth quarter while the clock is high.
- R2: Code 0101 produces a STOP slot: the data line is pulled low for the first three quarters and released at the start of the fourth quarter while the clock is high.
- R3: Code 0011 sends `tx_byte` most significant bit first over eight slots (pulled low for a 0, released for a 1), releases the data line in the ninth slot and stores the level read in that slot's third quarter in `ack_bit` (0 = acknowledged).
- R4: Code 0010 releases the data line for eight slots, shifts the level read in each slot's third quarter into `rx_byte` most significant bit first, and pulls the line low in the ninth slot as an acknowledge.
- R5: Code 0110 receives a byte as in R4 but keeps the data line released in the ninth slot (no acknowledge).
- R6: With the clock running, `scl_o` has a period of four quarters and continues between commands; code 0000 stops it high at the end of the current slot, and it stays high until the next bus command starts.
- R7: Any code other than 0000, 0010, 0011, 0101, 0110 and 1001 written while idle sets `error`, leaves `busy` low and changes nothing on the bus.
- R8: `busy` rises in the cycle after a command is accepted and falls at the end of its last slot; a write made while `busy` is high changes neither the bus nor `error`.
- R9: `error` is cleared by `err_clear` or by the acceptance of a valid command; an invalid write in the same cycle as `err_clear` leaves it set.
- R10: While the clock stays high, the data line changes only during a START or STOP slot.
- R11: After reset `busy` and `error` are 0, `scl_o` is high, the data line is released and the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_we | input | 1 | Command write strobe, one cycle |
| cmd_code | input | 4 | Command code written with `cmd_we` |
| tx_byte | input | 8 | Byte to send, captured with a transmit command |
| err_clear | input | 1 | Clears the error flag |
| sda_i | input | 1 | Level read back from the data line |
| busy | output | 1 | High while a command is pending or running |
| error | output | 1 | Set by an undefined command code |
| rx_byte | output | 8 | Byte assembled by the last receive |
| ack_bit | output | 1 | Level read in the ninth slot of the last transmit |
| scl_o | output | 1 | Bus clock level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench chases the slot boundary: commands are written mid-slot while the clock runs and again after it has been halted, so a design that starts early would clip the first clock-low phase and one that starts late would add a stray idle slot, both visible against the reference on every clock. Transmits are run with the slave acknowledging and then refusing, and receives with and without an acknowledge, so a reversed bit order, an acknowledge sampled in the wrong quarter or the two receive codes swapped all show up as wrong levels or bytes. Writes made while busy, undefined codes and the error clear are mixed in, catching a design that lets a late write queue a STOP or set the error flag.

// File: rtl/ee_cmd_pkg.sv
// Shared command codes and helpers for the EEPROM byte command engine.
// Assumes 4-bit command codes and one bus bit per four-quarter slot.
package ee_cmd_pkg;

    typedef enum logic [3:0] {
        OP_HALT    = 4'b0000,
        OP_RD_ACK  = 4'b0010,
        OP_WR      = 4'b0011,
        OP_STOP    = 4'b0101,
        OP_RD_LAST = 4'b0110,
        OP_START   = 4'b1001
    } op_e;

    localparam int BYTE_BITS  = 8;
    localparam int SLOT_W     = 4;
    localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(BYTE_BITS);

    // True for the six defined command codes.
    function automatic logic op_is_valid(input logic [3:0] code);
        return (code == OP_HALT) || (code == OP_RD_ACK) || (code == OP_WR) ||
               (code == OP_STOP) || (code == OP_RD_LAST) || (code == OP_START);
    endfunction

    // Index of the final slot of a command.
    function automatic logic [SLOT_W-1:0] op_last_slot(input op_e op);
        return (op == OP_START || op == OP_STOP) ? '0 : ACK_SLOT;
    endfunction

    // True for both receive commands.
    function automatic logic op_is_read(input op_e op);
        return (op == OP_RD_ACK) || (op == OP_RD_LAST);
    endfunction

endpackage

// File: rtl/ee_qtr_timer.sv
// Quarter-period divider: pulses tick once every QTR_CYCLES clocks.
// Assumes QTR_CYCLES >= 1; the counter runs freely out of reset.
module ee_qtr_timer #(
    parameter int QTR_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (QTR_CYCLES <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(QTR_CYCLES);
            localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);
            logic [CW-1:0] cnt;

            // Count clocks within one quarter period.
            always_ff @(posedge clk) begin
                if (!rst_n) cnt <= '0;
                else        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end

            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/ee_sda_drive.sv
// Decides whether the data line is pulled low in the current quarter.
// Assumes q counts quarters 0..3 of a slot, quarters 2 and 3 with clock high.
module ee_sda_drive
    import ee_cmd_pkg::*;
(
    input  logic                active,
    input  op_e                 op,
    input  logic [1:0]          q,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [7:0]          txd,
    input  logic                hold_low,
    output logic                sda_low
);
    // Select the pull-low level from command, slot and quarter.
    always_comb begin
        sda_low = hold_low;
        if (active) begin
            unique case (op)
                OP_START:   sda_low = (q == 2'd3);
                OP_STOP:    sda_low = (q != 2'd3);
                OP_WR:      sda_low = (slot < ACK_SLOT) ? !txd[3'd7 - slot[2:0]] : 1'b0;
                OP_RD_ACK:  sda_low = (slot == ACK_SLOT);
                OP_RD_LAST: sda_low = 1'b0;
                default:    sda_low = hold_low;
            endcase
        end
    end
endmodule

// File: rtl/ee_rx_capture.sv
// Shift register for received bits and the acknowledge flag.
// Assumes the strobes are single-cycle pulses in the sampling quarter.
module ee_rx_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       ack_en,
    input  logic       sda_i,
    output logic [7:0] rx_byte,
    output logic       ack_bit
);
    // Shift in one data bit, MSB arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_byte <= '0;
        else if (shift_en) rx_byte <= {rx_byte[6:0], sda_i};
    end

    // Hold the slave's answer from the ninth transmit slot.
    always_ff @(posedge clk) begin
        if (!rst_n)      ack_bit <= 1'b0;
        else if (ack_en) ack_bit <= sda_i;
    end
endmodule

// File: rtl/ee_byte_master.sv
// Two-wire bus master run one primitive per command code.
// Commands start on the next slot boundary; the clock free-runs between
// commands until the halt code parks it high. Assumes sda_i is synchronous.
module ee_byte_master
    import ee_cmd_pkg::*;
#(
    parameter int QTR_CYCLES = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [3:0] cmd_code,
    input  logic [7:0] tx_byte,
    input  logic       err_clear,
    input  logic       sda_i,
    output logic       busy,
    output logic       error,
    output logic [7:0] rx_byte,
    output logic       ack_bit,
    output logic       scl_o,
    output logic       sda_oe
);
    logic              tick;
    logic [1:0]        q;
    logic              running;
    logic              active;
    op_e               op;
    logic [SLOT_W-1:0] slot;
    logic [7:0]        txd;
    logic              hold_low;
    logic              sda_low;
    logic              boundary, fin, launch, run_nxt, accept;
    logic              smp_rx, smp_ack;

    ee_qtr_timer #(.QTR_CYCLES(QTR_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    ee_sda_drive i_drive (
        .active(active), .op(op), .q(q), .slot(slot), .txd(txd),
        .hold_low(hold_low), .sda_low(sda_low)
    );

    ee_rx_capture i_cap (
        .clk(clk), .rst_n(rst_n), .shift_en(smp_rx), .ack_en(smp_ack),
        .sda_i(sda_i), .rx_byte(rx_byte), .ack_bit(ack_bit)
    );

    // Slot boundary events and the clock state for the next slot.
    always_comb begin
        boundary = tick && (q == 2'd3);
        fin      = boundary && active && (slot == op_last_slot(op));
        launch   = boundary && busy && !active;
        run_nxt  = launch ? (op != OP_HALT) : running;
        accept   = cmd_we && !busy;
        smp_rx   = tick && (q == 2'd2) && active && op_is_read(op) && (slot < ACK_SLOT);
        smp_ack  = tick && (q == 2'd2) && active && (op == OP_WR) && (slot == ACK_SLOT);
    end

    // Quarter position and whether the bus clock is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= 2'd3;
            running <= 1'b0;
        end else if (tick) begin
            running <= run_nxt;
            q       <= (q == 2'd3) ? (run_nxt ? 2'd0 : 2'd3) : q + 2'd1;
        end
    end

    // Command acceptance, slot sequencing and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            active   <= 1'b0;
            op       <= OP_HALT;
            slot     <= '0;
            txd      <= '0;
            hold_low <= 1'b0;
        end else begin
            if (fin) begin
                active   <= 1'b0;
                busy     <= 1'b0;
                hold_low <= sda_low;
            end else if (boundary && active) begin
                slot <= slot + 1'b1;
            end
            if (launch) begin
                if (op == OP_HALT) begin
                    busy <= 1'b0;
                end else begin
                    active <= 1'b1;
                    slot   <= '0;
                end
            end
            if (accept && op_is_valid(cmd_code)) begin
                busy <= 1'b1;
                op   <= op_e'(cmd_code);
                txd  <= tx_byte;
            end
        end
    end

    // Error flag: set by undefined codes, cleared by valid codes or software.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   error <= 1'b0;
        else if (accept && !op_is_valid(cmd_code))    error <= 1'b1;
        else if (accept || err_clear)                 error <= 1'b0;
    end

    assign scl_o  = q[1];
    assign sda_oe = sda_low;

    // R6: a stopped clock is parked high.
    p_park_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> scl_o);

    // R7: an undefined code raises error and starts nothing.
    p_bad_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && !op_is_valid(cmd_code)) |=> (error && !busy));

    // R8: writes during busy leave the error flag alone.
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we && !err_clear) |=> (error == $past(error)));

    // R9: an accepted valid code clears error and raises busy.
    p_valid_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && op_is_valid(cmd_code)) |=> (busy && !error));

    // R10: data moves under a high clock only inside START or STOP.
    p_sda_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_oe != $past(sda_oe)))
            |-> (active && (op == OP_START || op == OP_STOP)));
endmodule

// File: tb/test_ee_byte_master.sv
// Bench: behavioural reference built from a queue of quarter levels,
// compared with the design on every clock, plus a small slave model.
module test_ee_byte_master;
    localparam int QTR = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [3:0] cmd_code = 4'd0;
    logic [7:0] tx_byte = 8'd0;
    logic       err_clear = 1'b0;
    logic       sda_i;
    logic       busy, error, ack_bit, scl_o, sda_oe;
    logic [7:0] rx_byte;

    always #2 clk = ~clk;

    ee_byte_master #(.QTR_CYCLES(QTR)) i_ee_byte_master (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .tx_byte(tx_byte), .err_clear(err_clear), .sda_i(sda_i),
        .busy(busy), .error(error), .rx_byte(rx_byte), .ack_bit(ack_bit),
        .scl_o(scl_o), .sda_oe(sda_oe)
    );

    int n_run = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    // ---------------- slave model ----------------
    bit        slv_en = 1'b0;
    logic [8:0] slv_bits = 9'h1FF;
    int        ptr = 9;
    logic      slv_low;
    always @(negedge scl_o) if (slv_en) ptr = ptr - 1;
    always_comb slv_low = slv_en && (ptr >= 0) && (ptr <= 8) && !slv_bits[ptr[3:0]];
    assign sda_i = !sda_oe && !slv_low;

    // ---------------- reference model ----------------
    int   mcnt, mq, cur;
    bit   mrun, mbusy, mact, mhold, merr, mack;
    logic [3:0] mop;
    logic [7:0] mtx, mrx;
    int   qq[$];

    function automatic bit valid_code(input logic [3:0] c);
        return c == 4'h0 || c == 4'h2 || c == 4'h3 || c == 4'h5 || c == 4'h6 || c == 4'h9;
    endfunction

    task automatic push4(input int a, input int b, input int c, input int d);
        qq.push_back(a); qq.push_back(b); qq.push_back(c); qq.push_back(d);
    endtask

    task automatic build_queue();
        qq.delete();
        case (mop)
            4'h9: push4(0, 0, 0, 1);
            4'h5: push4(1, 1, 1, 0);
            4'h3: begin
                for (int i = 0; i < 8; i++) begin
                    int b;
                    b = mtx[7-i] ? 0 : 1;
                    push4(b, b, b, b);
                end
                push4(0, 0, 4, 0);
            end
            default: begin
                for (int i = 0; i < 8; i++) push4(0, 0, 2, 0);
                if (mop == 4'h2) push4(1, 1, 1, 1);
                else             push4(0, 0, 0, 0);
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt = 0; mq = 3; cur = 0; mrun = 0; mbusy = 0; mact = 0;
            mhold = 0; merr = 0; mack = 0; mop = 4'h0; mtx = 8'h00; mrx = 8'h00;
            qq.delete();
        end else begin
            bit b0, tk;
            b0 = mbusy;
            tk = (mcnt == QTR - 1);
            mcnt = tk ? 0 : mcnt + 1;
            if (tk) begin
                if (mq == 2 && mact) begin
                    if (cur[1]) mrx = {mrx[6:0], sda_i};
                    if (cur[2]) mack = sda_i;
                end
                if (mq == 3) begin
                    if (mact && qq.size() == 0) begin
                        mhold = cur[0]; mact = 0; mbusy = 0;
                    end
                    if (mbusy && !mact) begin
                        if (mop == 4'h0) begin
                            mrun = 0; mbusy = 0;
                        end else begin
                            build_queue(); mact = 1; mrun = 1;
                        end
                    end
                    mq = mrun ? 0 : 3;
                    if (mact) cur = qq.pop_front();
                end else begin
                    mq = mq + 1;
                    if (mact) cur = qq.pop_front();
                end
            end
            if (cmd_we && !b0) begin
                if (valid_code(cmd_code)) begin
                    mbusy = 1; mop = cmd_code; mtx = tx_byte; merr = 0;
                end else begin
                    merr = 1;
                end
            end else if (err_clear) begin
                merr = 0;
            end
        end
    end

    // ---------------- bus monitors ----------------
    logic p_scl = 1'b1, p_sda = 1'b0;
    int   fall_hi = 0, rise_hi = 0, nfall = 0;
    bit   ninth_low = 1'b0;
    always @(negedge scl_o) nfall++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the reference, sampled at the falling edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            bit e_scl, e_sda;
            e_scl = (mq >= 2);
            e_sda = mact ? cur[0] : mhold;
            chk(scl_o == e_scl,  "R6 scl_o",   scl_o,  e_scl);
            chk(sda_oe == e_sda, "R10 sda_oe", sda_oe, e_sda);
            chk(busy == mbusy,   "R8 busy",    busy,   mbusy);
            chk(error == merr,   "R9 error",   error,  merr);
            chk(rx_byte == mrx,  "R4 rx_byte", rx_byte, mrx);
            chk(ack_bit == mack, "R3 ack_bit", ack_bit, mack);
            if (scl_o && p_scl && sda_oe && !p_sda) fall_hi++;
            if (scl_o && p_scl && !sda_oe && p_sda) rise_hi++;
            if (slv_en && ptr == 0 && scl_o && sda_oe) ninth_low = 1'b1;
        end
        p_scl = scl_o;
        p_sda = sda_oe;
    end

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: busy=%0b expected 0", busy);
        finish_up();
    end

    // Write a command, avoiding the cycle whose edge is a quarter tick.
    task automatic poke(input logic [3:0] code, input logic [7:0] data, input bit clr);
        @(negedge clk);
        while (mcnt == QTR - 1) @(negedge clk);
        cmd_we = 1'b1; cmd_code = code; tx_byte = data; err_clear = clr;
        @(negedge clk);
        cmd_we = 1'b0; err_clear = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Run a bus command with the slave presenting the given nine bits.
    task automatic run_cmd(input logic [3:0] code, input logic [7:0] data, input logic [8:0] sbits);
        ninth_low = 1'b0;
        slv_bits = sbits; ptr = 9; slv_en = 1'b1;
        poke(code, data, 1'b0);
        wait_idle();
        slv_en = 1'b0;
    endtask

    initial begin
        int f0, r0, n0;
        repeat (5) @(negedge clk);
        // R11: reset state.
        chk(busy == 0 && error == 0, "R11 busy/error", {busy, error}, 0);
        chk(scl_o == 1 && sda_oe == 0, "R11 scl/sda", {scl_o, sda_oe}, 2);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (10) @(negedge clk);
        chk(scl_o == 1, "R11 clock stopped", scl_o, 1);

        // R1: START from a stopped clock.
        f0 = fall_hi;
        run_cmd(4'h9, 8'h00, 9'h1FF);
        chk(fall_hi == f0 + 1, "R1 start edge", fall_hi - f0, 1);

        // R3: transmit, slave acknowledges then refuses.
        run_cmd(4'h3, 8'hA5, 9'h1FE);
        chk(ack_bit == 0, "R3 ack", ack_bit, 0);
        run_cmd(4'h3, 8'h3C, 9'h1FF);
        chk(ack_bit == 1, "R3 nack", ack_bit, 1);

        // R4: receive with acknowledge.
        run_cmd(4'h2, 8'h00, {8'h96, 1'b1});
        chk(rx_byte == 8'h96, "R4 rx byte", rx_byte, 8'h96);
        chk(ninth_low == 1, "R4 ack driven", ninth_low, 1);

        // R5: final receive without acknowledge.
        run_cmd(4'h6, 8'h00, {8'h5B, 1'b1});
        chk(rx_byte == 8'h5B, "R5 rx byte", rx_byte, 8'h5B);
        chk(ninth_low == 0, "R5 no ack", ninth_low, 0);

        // R2: STOP.
        r0 = rise_hi;
        run_cmd(4'h5, 8'h00, 9'h1FF);
        chk(rise_hi == r0 + 1, "R2 stop edge", rise_hi - r0, 1);

        // R6: clock keeps running between commands.
        n0 = nfall;
        repeat (8 * QTR) @(negedge clk);
        chk(nfall >= n0 + 1, "R6 free running", nfall - n0, 1);

        // R6: halt parks the clock high.
        run_cmd(4'h0, 8'h00, 9'h1FF);
        n0 = nfall;
        repeat (12 * QTR) @(negedge clk);
        chk(nfall == n0 && scl_o == 1, "R6 halted", nfall - n0, 0);

        // R7: undefined code.
        n0 = nfall;
        poke(4'h7, 8'h00, 1'b0);
        @(negedge clk);
        chk(error == 1 && busy == 0, "R7 error set", {error, busy}, 2);
        repeat (6 * QTR) @(negedge clk);
        chk(nfall == n0 && scl_o == 1, "R7 no bus activity", nfall - n0, 0);

        // R9: software clear, then invalid+clear keeps it set, then valid clears.
        poke(4'h0, 8'h00, 1'b1);
        cmd_we = 1'b0;
        wait_idle();
        poke(4'hC, 8'h00, 1'b0);
        @(negedge clk);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        chk(error == 0, "R9 clear", error, 0);
        poke(4'hE, 8'h00, 1'b1);
        chk(error == 1, "R9 set wins", error, 1);
        f0 = fall_hi;
        run_cmd(4'h9, 8'h00, 9'h1FF);
        chk(error == 0, "R9 valid clears", error, 0);
        chk(fall_hi == f0 + 1, "R1 start after halt", fall_hi - f0, 1);

        // R8: writes while busy are dropped.
        r0 = rise_hi;
        slv_bits = 9'h1FF; ptr = 9; slv_en = 1'b1;
        poke(4'h3, 8'hFF, 1'b0);
        poke(4'h5, 8'h00, 1'b0);
        poke(4'hF, 8'h00, 1'b0);
        chk(error == 0 && busy == 1, "R8 busy write ignored", {error, busy}, 1);
        wait_idle();
        slv_en = 1'b0;
        repeat (8 * QTR) @(negedge clk);
        chk(rise_hi == r0, "R8 no stop queued", rise_hi - r0, 0);

        run_cmd(4'h5, 8'h00, 9'h1FF);
        run_cmd(4'h0, 8'h00, 9'h1FF);
        repeat (4) @(negedge clk);
        chk(scl_o == 1 && sda_oe == 0 && busy == 0, "R6 final idle", {scl_o, sda_oe, busy}, 4);
        finish_up();
    end
endmodule